// File: doc/BRIEF.md
# Indexed interrupt routing controller

This block collects interrupts from a set of input pins and turns each qualified event into a delivery message. The message names a vector, a delivery mode, a destination mode and an 8-bit destination. Software never addresses the internal registers directly. It first loads an 8-bit selector into an index window, then reads or writes the selected 32-bit register through a data window. The internal registers are a controller ID, a read-only size and version word, an arbitration ID and one 64-bit routing entry per pin. Each routing entry is split over two consecutive selector values.

Every pin is sampled on each clock. Its polarity bit is applied first, and the pin is then treated as edge-triggered or level-triggered. An edge pin holds one pending request per inactive-to-active transition. A level pin requests while it stays active, until its message is accepted. It is then blocked by a remote-IRR flag until an end-of-interrupt with a matching vector arrives. When several pins are pending, the lowest-numbered pin wins and one message is offered per cycle. The message stays offered until the receiver accepts it.

Top module: `irq_router`

## Requirements
- R1: The register port always accepts (`reg_ready`=1). Word address 0 is the index window: a write loads `reg_wdata[7:0]` and a read returns the index in bits [7:0]. Word address 4 is the data window and reaches the register that the index selects. Any other word address reads 0 and ignores writes. Read data and `rd_valid` appear in the cycle after the read is accepted.
- R2: Selector 0 holds the controller ID in bits [27:24], which is writable and reads back as written. All other bits of this register read 0.
- R3: Selector 1 is read-only and reads `{8'h00, pins-1, 8'h00, version}`, which is 0x00170011 with 24 pins.
- R4: Selector 2 holds a writable arbitration ID in bits [27:24], with all other bits 0. Selectors outside 0–2 and outside the entry range read 0.
- R5: Pin n's low word is at selector 0x10+2n and its high word at 0x11+2n. After reset every low word reads 0x00010000 (masked) and every high word reads 0.
- R6: Low word layout: vector [7:0], delivery mode [10:8], logical destination mode [11], delivery status [12] (read-only), polarity [13] (1 = active low), remote IRR [14] (read-only), trigger [15] (1 = level), mask [16] (1 = masked). The destination is in bits [31:24] of the high word. Writes to bits 12 and 14 have no effect.
- R7: For an unmasked edge pin, an inactive-to-active transition (after polarity) sampled at a clock edge makes `msg_valid` high after that edge. The message carries the entry's vector, delivery mode, destination mode and destination, and it is offered once.
- R8: An edge event that occurs while the pin is masked is dropped: unmasking the pin later produces no message.
- R9: An entry whose destination is 0x00 produces no message and shows delivery status 0, even while it is unmasked.
- R10: A level pin requests while it is active, unmasked and has remote IRR clear. Acceptance sets remote IRR, which blocks further messages. An end-of-interrupt whose vector differs leaves the pin blocked. One whose vector matches clears remote IRR, and the pin requests again if it is still active.
- R11: Among simultaneous requests the lowest-numbered pin is offered first, with one message accepted per cycle.
- R12: The delivery status bit reads 1 while a pin's request waits with `msg_ready` low. It reads 0 once the message has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request ready (always 1) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address: 0 index window, 4 data window |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_mode | output | 1 | Message destination mode (1 logical) |
| msg_dest | output | 8 | Message destination |

## Verification
A read returns its data one clock after the accepting edge. A pin change is sampled at one edge, and its message is offered right after that edge. Acceptance at an edge takes the message down, sets remote IRR and clears delivery status before the next edge. A matching end-of-interrupt clears remote IRR at its edge, and a still-active level pin is offered again immediately after it. The bench drives every input on the falling clock edge and samples outputs on the next falling edge, so each check lands exactly one rising edge after its stimulus.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Stored part of one routing entry; delivery status and remote IRR live in the pin logic.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dst_logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } route_t;

  localparam logic [2:0] WIN_INDEX      = 3'd0;
  localparam logic [2:0] WIN_DATA       = 3'd4;
  localparam logic [7:0] SEL_ID         = 8'h00;
  localparam logic [7:0] SEL_VER        = 8'h01;
  localparam logic [7:0] SEL_ARB        = 8'h02;
  localparam logic [7:0] SEL_ENTRY_BASE = 8'h10;
  localparam int         ID_LSB         = 24;

  localparam route_t ROUTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                     dst_logical: 1'b0, dmode: 3'd0, vector: 8'h00};

  function automatic logic [31:0] pack_low(route_t e, logic dstat, logic rirr);
    return {15'd0, e.mask, e.trig, rirr, e.pol, dstat, e.dst_logical, e.dmode, e.vector};
  endfunction

  // Bits 12 and 14 are status and are not taken from the write data.
  function automatic route_t apply_low(route_t e, logic [31:0] w);
    route_t r;
    r             = e;
    r.vector      = w[7:0];
    r.dmode       = w[10:8];
    r.dst_logical = w[11];
    r.pol         = w[13];
    r.trig        = w[15];
    r.mask        = w[16];
    return r;
  endfunction

endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       active_low,
  input  logic       level_mode,
  input  logic       masked,
  input  logic       dest_ok,
  input  logic [7:0] vector,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  input  logic       accept,
  output logic       req,
  output logic       rirr
);

  logic act_q, act_d;
  logic pend_q, pend_d;
  logic rirr_q, rirr_d;
  logic edge_seen, lvl_req;

  assign act_d     = pin ^ active_low;
  assign edge_seen = act_d & ~act_q;
  assign lvl_req   = act_q & ~masked & dest_ok & ~rirr_q;

  always_comb begin
    pend_d = pend_q;
    if (accept)
      pend_d = 1'b0;
    if (!level_mode && edge_seen && !masked && dest_ok)
      pend_d = 1'b1;
    if (level_mode || masked || !dest_ok)
      pend_d = 1'b0;
  end

  always_comb begin
    rirr_d = rirr_q;
    if (level_mode && accept)
      rirr_d = 1'b1;
    else if (!level_mode || (eoi_valid && (eoi_vector == vector)))
      rirr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  assign req  = level_mode ? lvl_req : pend_q;
  assign rirr = rirr_q;

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i])
        idx = IW'(i);
  end

  assign any = |req;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter int         ID_W     = 4,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_valid,
  output logic                reg_ready,
  input  logic                reg_write,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_mode,
  output logic                msg_dest_mode,
  output logic [7:0]          msg_dest
);

  localparam int         PW        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [7:0] MAX_ENTRY = 8'(NUM_PINS - 1);
  localparam logic [7:0] SEL_END   = 8'(16 + 2 * NUM_PINS);

  logic [7:0]          index_q, index_d;
  logic [ID_W-1:0]     id_q, id_d, arb_q, arb_d;
  route_t              entry_q [NUM_PINS];
  route_t              entry_d [NUM_PINS];
  logic                rd_valid_q, rd_valid_d;
  logic [31:0]         rd_data_q, rd_data_d;
  logic [NUM_PINS-1:0] req_vec, rirr_vec, trig_vec, accept_vec;
  logic [PW-1:0]       grant_idx;
  logic                any_req;
  logic                acc_cyc, wr_index, wr_data, rd_cyc;
  logic                ent_hit, ent_high;
  logic [7:0]          ent_off;
  logic [PW-1:0]       ent_sel;
  logic [31:0]         data_rd;
  logic                wdata_unused;

  assign wdata_unused = ^reg_wdata[23:17];

  // Register port decode
  assign reg_ready = 1'b1;
  assign acc_cyc   = reg_valid & reg_ready;
  assign wr_index  = acc_cyc & reg_write & (reg_addr == WIN_INDEX);
  assign wr_data   = acc_cyc & reg_write & (reg_addr == WIN_DATA);
  assign rd_cyc    = acc_cyc & ~reg_write;
  assign ent_off   = index_q - SEL_ENTRY_BASE;
  assign ent_hit   = (index_q >= SEL_ENTRY_BASE) && (index_q < SEL_END);
  assign ent_sel   = PW'(ent_off >> 1);
  assign ent_high  = ent_off[0];

  always_comb begin
    data_rd = '0;
    if (index_q == SEL_ID)
      data_rd[ID_LSB +: ID_W] = id_q;
    else if (index_q == SEL_VER)
      data_rd = {8'h00, MAX_ENTRY, 8'h00, VERSION};
    else if (index_q == SEL_ARB)
      data_rd[ID_LSB +: ID_W] = arb_q;
    else if (ent_hit)
      data_rd = ent_high ? {entry_q[ent_sel].dest, 24'h000000}
                         : pack_low(entry_q[ent_sel], req_vec[ent_sel], rirr_vec[ent_sel]);
  end

  // Next state of the register file
  always_comb begin
    index_d    = index_q;
    id_d       = id_q;
    arb_d      = arb_q;
    entry_d    = entry_q;
    rd_valid_d = rd_cyc;
    rd_data_d  = rd_data_q;
    if (wr_index)
      index_d = reg_wdata[7:0];
    if (rd_cyc) begin
      if (reg_addr == WIN_INDEX)
        rd_data_d = {24'h000000, index_q};
      else if (reg_addr == WIN_DATA)
        rd_data_d = data_rd;
      else
        rd_data_d = '0;
    end
    if (wr_data) begin
      if (index_q == SEL_ID)
        id_d = reg_wdata[ID_LSB +: ID_W];
      else if (index_q == SEL_ARB)
        arb_d = reg_wdata[ID_LSB +: ID_W];
      else if (ent_hit) begin
        if (ent_high)
          entry_d[ent_sel].dest = reg_wdata[31:24];
        else
          entry_d[ent_sel] = apply_low(entry_q[ent_sel], reg_wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= '0;
      id_q       <= '0;
      arb_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      for (int i = 0; i < NUM_PINS; i++)
        entry_q[i] <= ROUTE_RESET;
    end else begin
      index_q    <= index_d;
      id_q       <= id_d;
      arb_q      <= arb_d;
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
      entry_q    <= entry_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // Per-pin sensing and request state
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign trig_vec[g]   = entry_q[g].trig;
    assign accept_vec[g] = msg_valid & msg_ready & (grant_idx == PW'(g));

    irq_pin_ctl i_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (irq_pins[g]),
      .active_low (entry_q[g].pol),
      .level_mode (entry_q[g].trig),
      .masked     (entry_q[g].mask),
      .dest_ok    (entry_q[g].dest != 8'h00),
      .vector     (entry_q[g].vector),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .accept     (accept_vec[g]),
      .req        (req_vec[g]),
      .rirr       (rirr_vec[g])
    );
  end

  irq_lowest_pick #(.N(NUM_PINS), .IW(PW)) i_pick (
    .req (req_vec),
    .any (any_req),
    .idx (grant_idx)
  );

  assign msg_valid     = any_req;
  assign msg_vector    = entry_q[grant_idx].vector;
  assign msg_mode      = entry_q[grant_idx].dmode;
  assign msg_dest_mode = entry_q[grant_idx].dst_logical;
  assign msg_dest      = entry_q[grant_idx].dest;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_PINS = 24,
  parameter int PW       = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_valid,
  input logic                reg_ready,
  input logic                reg_write,
  input logic                rd_valid,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_dest,
  input logic [NUM_PINS-1:0] req_vec,
  input logic [NUM_PINS-1:0] trig_vec,
  input logic [NUM_PINS-1:0] rirr_vec,
  input logic [PW-1:0]       grant_idx
);

  p_read_data_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_ready && !reg_write) |=> rd_valid);

  p_write_no_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_ready && reg_write) |=> !rd_valid);

  p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((req_vec & ~({NUM_PINS{1'b1}} << grant_idx)) == '0));

  p_grant_is_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> req_vec[grant_idx]);

  p_zero_dest_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_dest != 8'h00));

  p_level_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && trig_vec[grant_idx]) |=> rirr_vec[$past(grant_idx)]);

endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS), .PW(PW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_write (reg_write),
  .rd_valid  (rd_valid),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_dest  (msg_dest),
  .req_vec   (req_vec),
  .trig_vec  (trig_vec),
  .rirr_vec  (rirr_vec),
  .grant_idx (grant_idx)
);

// File: tb/test_irq_router.sv
module test_irq_router;

  localparam int NP = 24;

  logic          clk;
  logic          rst_n;
  logic          reg_valid, reg_ready, reg_write;
  logic [2:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] irq_pins;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          msg_valid, msg_ready, msg_dest_mode;
  logic [7:0]    msg_vector, msg_dest;
  logic [2:0]    msg_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  irq_router #(.NUM_PINS(NP)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_pins(irq_pins),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_dest_mode(msg_dest_mode), .msg_dest(msg_dest)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic sel_rd(input logic [7:0] s, output logic [31:0] d);
    wr(3'd0, {24'd0, s});
    rd(3'd4, d);
  endtask

  task automatic entry_wr(input int p, input logic [31:0] lo, input logic [31:0] hi);
    wr(3'd0, 32'(8'h11 + 2 * p));
    wr(3'd4, hi);
    wr(3'd0, 32'(8'h10 + 2 * p));
    wr(3'd4, lo);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    irq_pins[p] = v;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R7 no message after reset", {31'd0, msg_valid}, 32'd0);
    sel_rd(8'h10, d); chk("R5 pin0 low reset", d, 32'h0001_0000);
    sel_rd(8'h3F, d); chk("R5 pin23 high reset", d, 32'h0);
    sel_rd(8'h3E, d); chk("R5 pin23 low reset", d, 32'h0001_0000);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(3'd0, 32'hABCD_EF23);
    rd(3'd0, d); chk("R1 index readback", d, 32'h23);
    rd(3'd1, d); chk("R1 unused word address", d, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h0200_0000);
    sel_rd(8'h00, d); chk("R2 id written 2", d, 32'h0200_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R2 id reserved bits", d, 32'h0F00_0000);
    wr(3'd4, 32'h0200_0000);
    sel_rd(8'h01, d); chk("R3 version word", d, 32'h0017_0011);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R3 version read-only", d, 32'h0017_0011);
    sel_rd(8'h02, d); chk("R4 arb reset", d, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R4 arb reserved bits", d, 32'h0F00_0000);
    sel_rd(8'h40, d); chk("R4 past last entry", d, 32'h0);
    sel_rd(8'h03, d); chk("R4 unmapped selector", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    entry_wr(20, 32'hFFFF_FFFF, 32'h0);
    sel_rd(8'h38, d); chk("R6 low layout, status bits ignored", d, 32'h0001_AFFF);
    wr(3'd0, 32'h39); wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R6 high layout", d, 32'hFF00_0000);
    entry_wr(20, 32'h0001_0000, 32'h0);
    sel_rd(8'h38, d); chk("R6 restore", d, 32'h0001_0000);
  endtask

  task automatic t_edge();
    entry_wr(4, 32'h0000_0964, 32'hFF00_0000);
    set_pin(4, 1'b1);
    @(negedge clk);
    chk("R7 edge message valid", {31'd0, msg_valid}, 32'd1);
    chk("R7 vector", {24'd0, msg_vector}, 32'h64);
    chk("R7 mode", {29'd0, msg_mode}, 32'd1);
    chk("R7 dest mode", {31'd0, msg_dest_mode}, 32'd1);
    chk("R7 dest", {24'd0, msg_dest}, 32'hFF);
    @(negedge clk);
    chk("R7 single message", {31'd0, msg_valid}, 32'd0);
    // active-low pin
    set_pin(1, 1'b1);
    entry_wr(1, 32'h0000_2021, 32'h0300_0000);
    @(negedge clk);
    chk("R7 no edge when idle high active-low", {31'd0, msg_valid}, 32'd0);
    set_pin(1, 1'b0);
    @(negedge clk);
    chk("R7 falling edge active-low", {24'd0, msg_valid ? msg_vector : 8'h00}, 32'h21);
    chk("R7 active-low dest", {24'd0, msg_dest}, 32'h03);
    @(negedge clk);
    chk("R7 active-low once", {31'd0, msg_valid}, 32'd0);
  endtask

  task automatic t_masked();
    entry_wr(7, 32'h0001_0047, 32'hFF00_0000);
    set_pin(7, 1'b1);
    @(negedge clk);
    chk("R8 masked edge no message", {31'd0, msg_valid}, 32'd0);
    entry_wr(7, 32'h0000_0047, 32'hFF00_0000);
    chk("R8 dropped after unmask", {31'd0, msg_valid}, 32'd0);
    @(negedge clk);
    chk("R8 still dropped", {31'd0, msg_valid}, 32'd0);
  endtask

  task automatic t_zero_dest();
    logic [31:0] d;
    entry_wr(2, 32'h0000_0042, 32'h0);
    set_pin(2, 1'b1);
    @(negedge clk);
    chk("R9 zero destination silent", {31'd0, msg_valid}, 32'd0);
    sel_rd(8'h14, d); chk("R9 status stays 0", d, 32'h0000_0042);
  endtask

  task automatic t_level();
    logic [31:0] d;
    entry_wr(5, 32'h0000_8045, 32'h0100_0000);
    set_pin(5, 1'b1);
    @(negedge clk);
    chk("R10 level delivers", {24'd0, msg_valid ? msg_vector : 8'h00}, 32'h45);
    @(negedge clk);
    chk("R10 blocked after accept", {31'd0, msg_valid}, 32'd0);
    sel_rd(8'h1A, d); chk("R10 remote IRR visible", d, 32'h0000_C045);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h46;
    @(negedge clk); eoi_valid = 1'b0;
    chk("R10 wrong vector keeps blocked", {31'd0, msg_valid}, 32'd0);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h45;
    @(negedge clk);
    chk("R10 redelivered after EOI", {24'd0, msg_valid ? msg_vector : 8'h00}, 32'h45);
    eoi_valid = 1'b0;
    @(negedge clk);
    chk("R10 blocked again", {31'd0, msg_valid}, 32'd0);
    set_pin(5, 1'b0);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h45;
    @(negedge clk); eoi_valid = 1'b0;
    chk("R10 inactive pin no request", {31'd0, msg_valid}, 32'd0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    entry_wr(3, 32'h0000_0033, 32'h0100_0000);
    entry_wr(9, 32'h0000_0039, 32'h0100_0000);
    @(negedge clk);
    msg_ready = 1'b0;
    irq_pins[3] = 1'b1; irq_pins[9] = 1'b1;
    @(negedge clk);
    chk("R11 lowest pin first", {24'd0, msg_valid ? msg_vector : 8'h00}, 32'h33);
    sel_rd(8'h16, d); chk("R12 status while waiting", d, 32'h0000_1033);
    chk("R12 message held", {24'd0, msg_valid ? msg_vector : 8'h00}, 32'h33);
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R11 next pin next cycle", {24'd0, msg_valid ? msg_vector : 8'h00}, 32'h39);
    @(negedge clk);
    chk("R11 queue drained", {31'd0, msg_valid}, 32'd0);
    sel_rd(8'h16, d); chk("R12 status cleared", d, 32'h0000_0033);
  endtask

  initial begin
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_pins = '0; eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_window();
    t_layout();
    t_edge();
    t_masked();
    t_zero_dest();
    t_level();
    t_priority();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule